// File: doc/BRIEF.md
# Instruction/Data Bank Conflict Monitor

This block is a passive observer placed next to a lower-memory arbiter that has one shared port for the instruction side and the data side. Each side presents a request, a grant and a physical address. The monitor assigns each address to one of four banks, interleaved on aligned 32-bit words. It then sorts every cycle in which both sides want lower memory into a same-bank or split-bank event. A split-bank cycle marks parallelism that a banked memory could have used and that the single port lost.

The instruction side carries demand fetches, prefetches, instruction-cache fills and instruction-side page-table walks. The data side carries loads, stores, store-buffer drains, floating-point memory accesses, atomics, data-cache fills and data-side page-table walks. The monitor treats each side as one request line and does not know which kind of traffic is on it. It counts into saturating registers, aggregate and per bank, that a simple indexed read port exposes. It drives nothing back into the arbiter.

Top module: `bank_overlap_monitor`

## Requirements
- R1: The bank of an address is bits [3:2], so banks 0 to 3 hold consecutive aligned words. No other address bit changes any counter.
- R2: Slot 0 counts cycles in which both sides request. In each such cycle exactly one other counter also increments: slot 1 if the two banks are equal, slot 2 if they differ.
- R3: Slot 3 counts cycles with the instruction request high and its grant low. Slot 4 counts the same for the data side.
- R4: A data-blocked cycle that happens while the instruction side also requests increments slot 5 if the banks differ, or slot 6 if they are equal.
- R5: For bank b, slot 8+4b counts cycles with an instruction request to bank b, and slot 9+4b counts cycles with a data request to bank b.
- R6: For bank b, slot 10+4b counts instruction grants to bank b and slot 11+4b counts data grants to bank b. A grant counts only while its request is high.
- R7: Each counter is CNT_W bits wide (default 32) and holds at its all-ones value instead of wrapping.
- R8: A high synchronous clear sets every counter to zero on the next edge. It takes priority over events in the same cycle.
- R9: rd_data shows the counter chosen by rd_idx one clock after rd_idx is presented.
- R10: Indices that hold no counter read as zero. With the default parameters these are 7 and 24 to 31.
- R11: An asynchronous active-low reset zeroes all counters and rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all counters |
| i_req | input | 1 | Instruction side wants lower memory |
| i_gnt | input | 1 | Arbiter grants the instruction side |
| i_addr | input | ADDR_W | Instruction-side physical address |
| d_req | input | 1 | Data side wants lower memory |
| d_gnt | input | 1 | Arbiter grants the data side |
| d_addr | input | ADDR_W | Data-side physical address |
| rd_idx | input | IDX_W | Counter index to read |
| rd_data | output | CNT_W | Counter value, one cycle after rd_idx |

## Verification
Any wrong internal state can only show up as a wrong value on rd_data. A counter that took an event in the wrong cycle, or sent it to the wrong bank, is seen the next time its index is read, one clock after the read is issued. Counters that should move together also expose errors: same-bank plus split-bank must equal both-want, and per-bank grants must never exceed per-bank wants. So a misclassified cycle produces a mismatch between related slots as well as a wrong absolute count. A saturation or clear fault appears only when the bench pushes a counter to its limit or pulses clear while events are active, so both cases are driven on purpose.

// File: rtl/bank_overlap_monitor.sv
module bank_overlap_monitor #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int BANK_LSB = 2,
  parameter int BANK_W   = 2,
  localparam int NBANK     = 1 << BANK_W,
  localparam int BANK_BASE = 8,
  localparam int NCNT      = BANK_BASE + 4 * NBANK,
  localparam int IDX_W     = $clog2(NCNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              i_req,
  input  logic              i_gnt,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic              d_req,
  input  logic              d_gnt,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_data
);

  localparam int S_BOTH      = 0;
  localparam int S_SAME      = 1;
  localparam int S_SPLIT     = 2;
  localparam int S_IBLK      = 3;
  localparam int S_DBLK      = 4;
  localparam int S_DBLK_SPL  = 5;
  localparam int S_DBLK_SAME = 6;

  logic [BANK_W-1:0] i_bank, d_bank;
  logic both, same_bank, i_blk, d_blk;
  logic [NCNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [NCNT*CNT_W-1:0] cnt_flat;
  logic unused_addr_bits;

  assign i_bank    = i_addr[BANK_LSB +: BANK_W];
  assign d_bank    = d_addr[BANK_LSB +: BANK_W];
  assign both      = i_req & d_req;
  assign same_bank = (i_bank == d_bank);
  assign i_blk     = i_req & ~i_gnt;
  assign d_blk     = d_req & ~d_gnt;
  assign unused_addr_bits = ^{i_addr, d_addr};

  always_comb begin
    inc = '0;
    inc[S_BOTH]      = both;
    inc[S_SAME]      = both & same_bank;
    inc[S_SPLIT]     = both & ~same_bank;
    inc[S_IBLK]      = i_blk;
    inc[S_DBLK]      = d_blk;
    inc[S_DBLK_SPL]  = d_blk & i_req & ~same_bank;
    inc[S_DBLK_SAME] = d_blk & i_req & same_bank;
    for (int b = 0; b < NBANK; b++) begin
      inc[BANK_BASE + 4*b + 0] = i_req & (i_bank == BANK_W'(b));
      inc[BANK_BASE + 4*b + 1] = d_req & (d_bank == BANK_W'(b));
      inc[BANK_BASE + 4*b + 2] = i_req & i_gnt & (i_bank == BANK_W'(b));
      inc[BANK_BASE + 4*b + 3] = d_req & d_gnt & (d_bank == BANK_W'(b));
    end
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt[k] <= '0;
      else if (clr)                      cnt[k] <= '0;
      else if (inc[k] && (cnt[k] != '1)) cnt[k] <= cnt[k] + 1'b1;
    end
    assign cnt_flat[k*CNT_W +: CNT_W] = cnt[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if ({1'b0, rd_idx} < (IDX_W+1)'(NCNT)) rd_data <= cnt[rd_idx];
    else rd_data <= '0;
  end

endmodule

// File: rtl/bank_overlap_monitor_chk.sv
module bank_overlap_monitor_chk #(
  parameter int CNT_W     = 32,
  parameter int NBANK     = 4,
  parameter int BANK_BASE = 8,
  parameter int NCNT      = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic [NCNT*CNT_W-1:0] cnt_flat
);

  logic [CNT_W-1:0] c_both, c_same, c_split, c_dblk, c_dspl, c_dsame;
  assign c_both  = cnt_flat[0*CNT_W +: CNT_W];
  assign c_same  = cnt_flat[1*CNT_W +: CNT_W];
  assign c_split = cnt_flat[2*CNT_W +: CNT_W];
  assign c_dblk  = cnt_flat[4*CNT_W +: CNT_W];
  assign c_dspl  = cnt_flat[5*CNT_W +: CNT_W];
  assign c_dsame = cnt_flat[6*CNT_W +: CNT_W];

  p_same_split_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_both != '1) |-> ({1'b0, c_same} + {1'b0, c_split} == {1'b0, c_both}));

  p_dblk_parts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dblk != '1) |-> ({1'b0, c_dspl} + {1'b0, c_dsame} <= {1'b0, c_dblk}));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_flat == '0));

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && c_both == '1) |=> (c_both == '1));

  p_no_decrease_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (c_both >= $past(c_both)));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    p_grant_le_want_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[(BANK_BASE+4*b+2)*CNT_W +: CNT_W] <= cnt_flat[(BANK_BASE+4*b+0)*CNT_W +: CNT_W]) &&
      (cnt_flat[(BANK_BASE+4*b+3)*CNT_W +: CNT_W] <= cnt_flat[(BANK_BASE+4*b+1)*CNT_W +: CNT_W]));
  end

endmodule

bind bank_overlap_monitor bank_overlap_monitor_chk #(
  .CNT_W(CNT_W), .NBANK(NBANK), .BANK_BASE(BANK_BASE), .NCNT(NCNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_flat(cnt_flat)
);

// File: tb/bank_overlap_monitor_tb_top.sv
`timescale 1ns/1ps
module bank_overlap_monitor_tb_top;
  localparam int CW = 6;
  localparam int NROW = 14;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic i_req = 0, i_gnt = 0, d_req = 0, d_gnt = 0;
  logic [31:0] i_addr = '0, d_addr = '0;
  logic [4:0] rd_idx = '0;
  logic [CW-1:0] rd_data;

  always #2.5 clk = ~clk;

  bank_overlap_monitor #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .i_req(i_req), .i_gnt(i_gnt), .i_addr(i_addr),
    .d_req(d_req), .d_gnt(d_gnt), .d_addr(d_addr),
    .rd_idx(rd_idx), .rd_data(rd_data));

  // row: {ireq, ignt, iaddr, dreq, dgnt, daddr, cls} cls 1=same 2=split 0=none
  localparam logic [69:0] ROWS [NROW] = '{
    {1'b1,1'b1,32'h0000_1000, 1'b1,1'b0,32'h0000_2000, 2'd1},
    {1'b1,1'b1,32'h0000_0004, 1'b1,1'b0,32'h0000_0008, 2'd2},
    {1'b1,1'b0,32'h0000_000C, 1'b1,1'b1,32'hFFFF_FF0C, 2'd1},
    {1'b1,1'b1,32'h0000_0013, 1'b0,1'b0,32'h0000_0004, 2'd0},
    {1'b0,1'b0,32'h0000_0000, 1'b1,1'b1,32'h8000_0006, 2'd0},
    {1'b0,1'b0,32'h0000_0000, 1'b1,1'b0,32'h0000_000B, 2'd0},
    {1'b1,1'b0,32'h0000_0008, 1'b0,1'b0,32'h0000_0000, 2'd0},
    {1'b1,1'b1,32'hABCD_EF04, 1'b1,1'b0,32'h1234_5678, 2'd2},
    {1'b1,1'b0,32'h0000_001C, 1'b1,1'b1,32'h0000_0024, 2'd2},
    {1'b1,1'b1,32'h0000_0030, 1'b1,1'b0,32'h0000_0040, 2'd1},
    {1'b0,1'b0,32'h0000_0000, 1'b0,1'b0,32'h0000_0000, 2'd0},
    {1'b1,1'b1,32'h0000_003C, 1'b1,1'b0,32'h0000_002C, 2'd1},
    {1'b1,1'b1,32'h0000_0014, 1'b1,1'b0,32'h0000_0018, 2'd2},
    {1'b0,1'b1,32'h0000_0000, 1'b0,1'b1,32'h0000_0000, 2'd0}
  };

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int ex [32];

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic rd(input int idx, output int v);
    @(negedge clk) rd_idx = 5'(idx);
    @(posedge clk);
    @(negedge clk) v = int'(rd_data);
  endtask

  function automatic string req_of(input int idx);
    if (idx <= 2) return "R2";
    if (idx <= 4) return "R3";
    if (idx <= 6) return "R4";
    if (idx == 7 || idx >= 24) return "R10";
    if ((idx % 4) < 2) return "R5/R1";
    return "R6";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int v, v0;
    foreach (ex[k]) ex[k] = 0;
    #1 check("R11 rd_data in reset", int'(rd_data), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, v);  check("R11 slot0 after reset", v, 0);
    rd(8, v);  check("R11 slot8 after reset", v, 0);

    for (int r = 0; r < NROW; r++) begin
      logic ir, ig, dr, dg;
      logic [31:0] ia, da;
      logic [1:0] cls;
      int ib, db;
      {ir, ig, ia, dr, dg, da, cls} = ROWS[r];
      @(negedge clk);
      i_req = ir; i_gnt = ig; i_addr = ia; d_req = dr; d_gnt = dg; d_addr = da;
      ib = int'(ia[3:2]); db = int'(da[3:2]);
      if (ir && dr) begin ex[0]++; if (cls == 1) ex[1]++; else ex[2]++; end
      if (ir && !ig) ex[3]++;
      if (dr && !dg) begin
        ex[4]++;
        if (ir) begin if (cls == 1) ex[6]++; else ex[5]++; end
      end
      if (ir) ex[8 + 4*ib]++;
      if (dr) ex[9 + 4*db]++;
      if (ir && ig) ex[10 + 4*ib]++;
      if (dr && dg) ex[11 + 4*db]++;
    end
    @(negedge clk);
    i_req = 0; i_gnt = 0; d_req = 0; d_gnt = 0; i_addr = '0; d_addr = '0;

    for (int k = 0; k < 32; k++) begin
      rd(k, v);
      check($sformatf("%s slot %0d", req_of(k), k), v, ex[k]);
    end

    // R9 latency
    rd(0, v0);
    @(negedge clk) rd_idx = 5'd2;
    #1 check("R9 old value before edge", int'(rd_data), v0);
    @(posedge clk);
    @(negedge clk) check("R9 new value after edge", int'(rd_data), ex[2]);

    // R7 saturation
    @(negedge clk);
    i_req = 1; i_gnt = 1; d_req = 1; d_gnt = 0; i_addr = 32'h4; d_addr = 32'h104;
    repeat (MAXV + 10) @(negedge clk);
    i_req = 0; i_gnt = 0; d_req = 0;
    rd(0, v);  check("R7 both saturates", v, MAXV);
    rd(1, v);  check("R7 same saturates", v, MAXV);
    rd(12, v); check("R7 bank1 i want saturates", v, MAXV);

    // R8 clear wins over activity
    @(negedge clk);
    clr = 1; i_req = 1; d_req = 1; d_gnt = 1;
    @(negedge clk);
    clr = 0; i_req = 0; d_req = 0; d_gnt = 0;
    rd(0, v);  check("R8 slot0 cleared", v, 0);
    rd(4, v);  check("R8 slot4 cleared", v, 0);
    rd(13, v); check("R8 slot13 cleared", v, 0);

    finish_run();
  end
endmodule